// File: doc/BRIEF.md
# Flash command write sequencer

This block sits between a simple register bus and a flash array. It enforces the three-write sequence that starts a program, sector-erase, mass-erase or erase-verify operation. The first write goes to the 64K array window with an aligned 16-bit word, and the block latches both the address and the data. The second write puts a command code into the command register. The third write sets the buffer-empty bit of the status register to 1, and that launches the operation toward the array model. The array model answers with a done pulse when the operation finishes.

Any write that breaks the ordering aborts the sequence, discards the latched buffers and raises an access-error flag. Writes into the protected part of the window raise a protection-violation flag. Each of the two 32K banks keeps its own pair of error flags, and a bank-select bit in the configuration register picks which pair is shown and updated. Register reads never disturb a sequence.

Register map (`bus_is_reg`=1, offset on `bus_addr[1:0]`):
- 0: bank select, in bit 0.
- 1: status.
  - Bit 7: buffer-empty. Writing 1 launches.
  - Bit 6: command-complete. Read-only.
  - Bit 5: protection violation. Write 1 to clear.
  - Bit 4: access error. Write 1 to clear.
- 2: command.
- 3: protection boundary. Reset value is 0xFFFF.

Command codes:
- 0x21: program.
- 0x42: sector erase.
- 0x44: mass erase.
- 0x06: erase verify.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, status reads 0x00C0 (buffer-empty=1, complete=1, both flags 0), bank select reads 0, and `arr_start` is low.
- R2: An aligned array write, then a known command write, then a status write with bit 7 set, produce a one-cycle `arr_start` in the cycle after the launch write. While the operation is busy, status bits 7 and 6 read 0.
- R3: An `arr_done` pulse while busy makes status bits 7 and 6 read 1 again.
- R4: At launch, `arr_cmd` carries the code and `arr_bank` carries the bank. Program passes the full address and the data. Erase verify and mass erase pass the address unchanged. Sector erase clears address bits 8:0. All erases send data 0.
- R5: An array write to an odd address sets access error (status bit 4) and starts no sequence.
- R6: A command write with no pending array write sets access error. So does a launch write (status bit 7 = 1) with no pending command.
- R7: Any write other than the expected next step sets access error and discards the sequence, so a later launch does not start. A bank-select write made during a sequence is not applied.
- R8: A command code other than the four listed sets access error and discards the sequence.
- R9: An array write at an address greater than or equal to the protection boundary sets the violation flag (status bit 5) and starts no sequence. Addresses below the boundary are accepted.
- R10: Writing 1 to status bit 4 or bit 5 clears that flag. While either flag is set, array writes are ignored.
- R11: Error flags are kept per bank, and status shows the flags of the selected bank.
- R12: Array, command and launch writes while busy set access error but do not affect the running operation.
- R13: Register reads return data in the cycle after `bus_rd`, at any point of a sequence, without changing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_is_reg | input | 1 | 1 selects the register space, 0 selects the array window |
| bus_addr | input | 16 | Byte address (register offset in bits 1:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| arr_start | output | 1 | One-cycle launch pulse to the array model |
| arr_cmd | output | 8 | Command code of the launched operation |
| arr_addr | output | 16 | Operation address |
| arr_data | output | 16 | Program data, or 0 for erases |
| arr_bank | output | 1 | Bank of the operation |
| arr_done | input | 1 | Operation finished pulse from the array model |

## Verification
The main sequence is tried with each of the four command codes and with both banks. Sector erase uses an address whose low nine bits are non-zero, which tells address shaping apart from plain pass-through. Data is a non-zero pattern on erases, which tells data masking apart from forwarding. Broken orderings are covered next: a misaligned word, a command first, a launch first, a doubled array write, a bank write mid-sequence, an unknown code, and writes while busy. Each ordering is followed by a probe write whose outcome differs depending on whether a sequence was left pending. A behavioural model follows the bus every clock and compares the launch payload and the read data.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  parameter int CMD_W = 8;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CMD  = 2'd2;
  localparam logic [1:0] REG_PROT = 2'd3;

  localparam int ST_BE = 7;
  localparam int ST_CC = 6;
  localparam int ST_PV = 5;
  localparam int ST_AE = 4;

  localparam logic [CMD_W-1:0] OP_PROG   = 8'h21;
  localparam logic [CMD_W-1:0] OP_SERASE = 8'h42;
  localparam logic [CMD_W-1:0] OP_MERASE = 8'h44;
  localparam logic [CMD_W-1:0] OP_VERIFY = 8'h06;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_CMD, S_BUSY} seq_st_t;
  typedef enum logic [2:0] {EV_NONE, EV_ARRAY, EV_CFG, EV_CMD, EV_STAT, EV_PROT} wr_ev_t;

  function automatic logic op_known(input logic [CMD_W-1:0] c);
    return (c == OP_PROG) || (c == OP_SERASE) || (c == OP_MERASE) || (c == OP_VERIFY);
  endfunction
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic       bus_wr,
  input  logic       bus_is_reg,
  input  logic [1:0] reg_sel,
  output wr_ev_t     ev
);
  always_comb begin
    ev = EV_NONE;
    if (bus_wr) begin
      if (!bus_is_reg) ev = EV_ARRAY;
      else begin
        case (reg_sel)
          REG_CFG:  ev = EV_CFG;
          REG_STAT: ev = EV_STAT;
          REG_CMD:  ev = EV_CMD;
          default:  ev = EV_PROT;
        endcase
      end
    end
  end
endmodule

// File: rtl/fcs_flags.sv
module fcs_flags #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic              set_ae,
  input  logic              set_pv,
  input  logic              clr_ae,
  input  logic              clr_pv,
  output logic              ae_o,
  output logic              pv_o
);
  logic [NUM_BANKS-1:0] ae_q, pv_q;

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          ae_q[g] <= 1'b0;
          pv_q[g] <= 1'b0;
        end else if (bank == BANK_W'(g)) begin
          if (set_ae)      ae_q[g] <= 1'b1;
          else if (clr_ae) ae_q[g] <= 1'b0;
          if (set_pv)      pv_q[g] <= 1'b1;
          else if (clr_pv) pv_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  assign ae_o = ae_q[bank];
  assign pv_o = pv_q[bank];
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int BANK_W      = 1,
  parameter int SECTOR_BITS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_ev_t            ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_hold,
  input  logic [ADDR_W-1:0] prot_lim,
  input  logic [BANK_W-1:0] bank,
  input  logic              arr_done,
  output logic              set_ae,
  output logic              set_pv,
  output logic              seq_open,
  output logic              buf_empty,
  output logic              cmd_done,
  output logic [CMD_W-1:0]  lat_cmd,
  output logic              arr_start,
  output logic [CMD_W-1:0]  arr_cmd,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic [BANK_W-1:0] arr_bank
);
  seq_st_t st, nxt;
  logic latch_buf, latch_cmd, launch, discard;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [ADDR_W-1:0] shaped_addr;
  logic launch_req;

  assign launch_req = (ev == EV_STAT) && wdata[ST_BE];

  always_comb begin
    nxt = st; set_ae = 1'b0; set_pv = 1'b0;
    latch_buf = 1'b0; latch_cmd = 1'b0; launch = 1'b0; discard = 1'b0;
    case (st)
      S_IDLE: begin
        if (ev == EV_ARRAY && !flag_hold) begin
          if (addr[0])                set_ae = 1'b1;
          else if (addr >= prot_lim)  set_pv = 1'b1;
          else begin latch_buf = 1'b1; nxt = S_ADDR; end
        end else if (ev == EV_CMD || launch_req) begin
          set_ae = 1'b1;
        end
      end
      S_ADDR: begin
        if (ev == EV_CMD && op_known(wdata[CMD_W-1:0])) begin
          latch_cmd = 1'b1; nxt = S_CMD;
        end else if (ev != EV_NONE) begin
          set_ae = 1'b1; discard = 1'b1; nxt = S_IDLE;
        end
      end
      S_CMD: begin
        if (launch_req) begin
          launch = 1'b1; nxt = S_BUSY;
        end else if (ev != EV_NONE) begin
          set_ae = 1'b1; discard = 1'b1; nxt = S_IDLE;
        end
      end
      default: begin
        if (ev == EV_ARRAY || ev == EV_CMD || launch_req) set_ae = 1'b1;
        if (arr_done) nxt = S_IDLE;
      end
    endcase
  end

  always_comb begin
    shaped_addr = lat_addr;
    if (lat_cmd == OP_SERASE) shaped_addr[SECTOR_BITS-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      lat_addr <= '0; lat_data <= '0; lat_cmd <= '0;
      buf_empty <= 1'b1; cmd_done <= 1'b1;
      arr_start <= 1'b0; arr_cmd <= '0; arr_addr <= '0; arr_data <= '0; arr_bank <= '0;
    end else begin
      st <= nxt;
      arr_start <= 1'b0;
      if (latch_buf) begin
        lat_addr <= addr;
        lat_data <= wdata;
      end
      if (latch_cmd) lat_cmd <= wdata[CMD_W-1:0];
      if (discard) begin
        lat_addr <= '0; lat_data <= '0; lat_cmd <= '0;
      end
      if (launch) begin
        arr_start <= 1'b1;
        arr_cmd   <= lat_cmd;
        arr_addr  <= shaped_addr;
        arr_data  <= (lat_cmd == OP_PROG) ? lat_data : '0;
        arr_bank  <= bank;
        buf_empty <= 1'b0;
        cmd_done  <= 1'b0;
      end
      if (st == S_BUSY && arr_done) begin
        buf_empty <= 1'b1;
        cmd_done  <= 1'b1;
      end
    end
  end

  assign seq_open = (st == S_ADDR) || (st == S_CMD);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int NUM_BANKS   = 2,
  parameter int SECTOR_BITS = 9,
  parameter logic [ADDR_W-1:0] PROT_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_is_reg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              arr_start,
  output logic [CMD_W-1:0]  arr_cmd,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] arr_bank,
  input  logic              arr_done
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  wr_ev_t ev;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] prot_q;
  logic ae_w, pv_w, set_ae, set_pv, clr_ae, clr_pv;
  logic seq_open, be_w, cc_w;
  logic [CMD_W-1:0] lat_cmd;
  logic [DATA_W-1:0] rd_mux;

  fcs_decode u_dec (
    .bus_wr(bus_wr), .bus_is_reg(bus_is_reg), .reg_sel(bus_addr[1:0]), .ev(ev)
  );

  assign clr_ae = (ev == EV_STAT) && bus_wdata[ST_AE];
  assign clr_pv = (ev == EV_STAT) && bus_wdata[ST_PV];

  fcs_flags #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_flags (
    .clk(clk), .rst(rst), .bank(bank_q),
    .set_ae(set_ae), .set_pv(set_pv), .clr_ae(clr_ae), .clr_pv(clr_pv),
    .ae_o(ae_w), .pv_o(pv_w)
  );

  fcs_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .SECTOR_BITS(SECTOR_BITS)) u_seq (
    .clk(clk), .rst(rst), .ev(ev), .addr(bus_addr), .wdata(bus_wdata),
    .flag_hold(ae_w | pv_w), .prot_lim(prot_q), .bank(bank_q), .arr_done(arr_done),
    .set_ae(set_ae), .set_pv(set_pv), .seq_open(seq_open),
    .buf_empty(be_w), .cmd_done(cc_w), .lat_cmd(lat_cmd),
    .arr_start(arr_start), .arr_cmd(arr_cmd), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_bank(arr_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      prot_q <= PROT_RST;
    end else if (!seq_open) begin
      if (ev == EV_CFG)  bank_q <= bus_wdata[BANK_W-1:0];
      if (ev == EV_PROT) prot_q <= bus_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr[1:0])
      REG_CFG:  rd_mux[BANK_W-1:0] = bank_q;
      REG_STAT: begin
        rd_mux[ST_BE] = be_w; rd_mux[ST_CC] = cc_w;
        rd_mux[ST_PV] = pv_w; rd_mux[ST_AE] = ae_w;
      end
      REG_CMD:  rd_mux[CMD_W-1:0] = lat_cmd;
      default:  rd_mux[ADDR_W-1:0] = prot_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_is_reg ? rd_mux : '0;
  end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SECTOR_BITS = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_is_reg,
  input logic [1:0]        reg_sel,
  input logic              launch_bit,
  input logic              arr_start,
  input logic [CMD_W-1:0]  arr_cmd,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_data,
  input logic              arr_done,
  input logic              be,
  input logic              cc,
  input logic [ADDR_W-1:0] prot_lim
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    arr_start |=> !arr_start); // R2
  AST_START_FROM_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> $past(bus_wr && bus_is_reg && reg_sel == REG_STAT && launch_bit)); // R2
  AST_BUSY_FLAGS_LOW: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> (!be && !cc)); // R2
  AST_DONE_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (!be && arr_done) |=> (be && cc)); // R3
  AST_SECTOR_BASE: assert property (@(posedge clk) disable iff (rst)
    (arr_start && arr_cmd == OP_SERASE) |-> (arr_addr[SECTOR_BITS-1:0] == '0)); // R4
  AST_ERASE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (arr_start && arr_cmd != OP_PROG) |-> (arr_data == '0)); // R4
  AST_PROG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (arr_start && arr_cmd == OP_PROG) |-> !arr_addr[0]); // R5
  AST_START_UNPROTECTED: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> (arr_addr < prot_lim)); // R9
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_BITS(SECTOR_BITS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_is_reg(bus_is_reg), .reg_sel(bus_addr[1:0]),
  .launch_bit(bus_wdata[fcs_pkg::ST_BE]), .arr_start(arr_start), .arr_cmd(arr_cmd),
  .arr_addr(arr_addr), .arr_data(arr_data), .arr_done(arr_done),
  .be(be_w), .cc(cc_w), .prot_lim(prot_q)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bus_is_reg = 0, arr_done = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic [15:0] bus_rdata, arr_addr, arr_data;
  logic [7:0] arr_cmd;
  logic arr_start;
  logic [0:0] arr_bank;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_is_reg(bus_is_reg),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arr_start(arr_start), .arr_cmd(arr_cmd), .arr_addr(arr_addr), .arr_data(arr_data),
    .arr_bank(arr_bank), .arr_done(arr_done)
  );

  // ---------------- behavioural reference model ----------------
  int m_st;                 // 0 idle, 1 address held, 2 command held, 3 busy
  bit m_ae[2], m_pv[2];
  int m_bank;
  int m_prot, m_addr, m_data, m_cmd;
  bit m_be, m_cc;
  bit exp_start;
  int exp_cmd, exp_addr, exp_data, exp_bank;
  int m_rdata;

  function automatic bit known(int c);
    return c == 'h21 || c == 'h42 || c == 'h44 || c == 'h06;
  endfunction

  function automatic int rdval(int off);
    case (off)
      0: return m_bank;
      1: return (int'(m_be) << 7) | (int'(m_cc) << 6) | (int'(m_pv[m_bank]) << 5) | (int'(m_ae[m_bank]) << 4);
      2: return m_cmd;
      default: return m_prot;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_ae = '{0, 0}; m_pv = '{0, 0}; m_bank = 0; m_prot = 'hFFFF;
      m_addr = 0; m_data = 0; m_cmd = 0; m_be = 1; m_cc = 1;
      exp_start = 0; m_rdata = 0;
    end else begin
      int kind, a, d;
      bit sae, spv, launch_w;
      int nbank, nprot;
      kind = !bus_wr ? 0 : (!bus_is_reg ? 1 : (bus_addr[1:0] == 0 ? 2 : bus_addr[1:0] == 1 ? 4 : bus_addr[1:0] == 2 ? 3 : 5));
      a = int'(bus_addr); d = int'(bus_wdata);
      if (bus_rd) m_rdata = bus_is_reg ? rdval(int'(bus_addr[1:0])) : 0;
      exp_start = 0; sae = 0; spv = 0;
      launch_w = (kind == 4) && d[7];
      nbank = m_bank; nprot = m_prot;
      if (kind == 2 && m_st != 1 && m_st != 2) nbank = d & 1;
      if (kind == 5 && m_st != 1 && m_st != 2) nprot = d;
      if (m_st == 0) begin
        if (kind == 1 && !m_ae[m_bank] && !m_pv[m_bank]) begin
          if (a % 2 == 1) sae = 1;
          else if (a >= m_prot) spv = 1;
          else begin m_addr = a; m_data = d; m_st = 1; end
        end else if (kind == 3 || launch_w) sae = 1;
      end else if (m_st == 1) begin
        if (kind == 3 && known(d & 'hFF)) begin m_cmd = d & 'hFF; m_st = 2; end
        else if (kind != 0) begin sae = 1; m_cmd = 0; m_st = 0; end
      end else if (m_st == 2) begin
        if (launch_w) begin
          exp_start = 1; exp_cmd = m_cmd; exp_bank = m_bank;
          exp_addr = (m_cmd == 'h42) ? (m_addr & 'hFE00) : m_addr;
          exp_data = (m_cmd == 'h21) ? m_data : 0;
          m_be = 0; m_cc = 0; m_st = 3;
        end else if (kind != 0) begin sae = 1; m_cmd = 0; m_st = 0; end
      end else begin
        if (kind == 1 || kind == 3 || launch_w) sae = 1;
        if (arr_done) begin m_be = 1; m_cc = 1; m_st = 0; end
      end
      if (sae) m_ae[m_bank] = 1; else if (kind == 4 && d[4]) m_ae[m_bank] = 0;
      if (spv) m_pv[m_bank] = 1; else if (kind == 4 && d[5]) m_pv[m_bank] = 0;
      m_bank = nbank; m_prot = nprot;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      tests++;
      if (arr_start !== exp_start) begin
        fails++; $display("FAIL R2 arr_start actual=%0b expected=%0b", arr_start, exp_start);
      end else if (exp_start && (arr_cmd != exp_cmd[7:0] || arr_addr != exp_addr[15:0] ||
                                 arr_data != exp_data[15:0] || arr_bank != exp_bank[0:0])) begin
        fails++; $display("FAIL R4 payload actual=%h/%h/%h/%0d expected=%h/%h/%h/%0d",
          arr_cmd, arr_addr, arr_data, arr_bank, exp_cmd[7:0], exp_addr[15:0], exp_data[15:0], exp_bank);
      end
      tests++;
      if (bus_rdata != m_rdata[15:0]) begin
        fails++; $display("FAIL R13 rdata actual=%h expected=%h", bus_rdata, m_rdata[15:0]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic isreg, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_is_reg = isreg; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk); bus_rd = 1; bus_is_reg = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); arr_done = 1;
    @(negedge clk); arr_done = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stat_is(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(16'd1, v); chk(req, v, exp);
  endtask

  task automatic launch_op(input logic [15:0] a, input logic [15:0] d, input logic [15:0] op);
    wr(0, a, d); wr(1, 16'd2, op); wr(1, 16'd1, 16'h0080);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      finished = 1; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    stat_is("R1 status", 16'h00C0);
    rd(16'd0, v); chk("R1 bank", v, 16'h0000);
    chk("R1 start", {15'b0, arr_start}, 16'h0000);

    // R2/R4/R13 program with read mid-sequence
    wr(0, 16'h1234, 16'hBEEF); wr(1, 16'd2, 16'h0021);
    stat_is("R13 read mid-sequence", 16'h00C0);
    wr(1, 16'd1, 16'h0080);
    chk("R2 start", {15'b0, arr_start}, 16'h0001);
    chk("R4 prog addr", arr_addr, 16'h1234);
    chk("R4 prog data", arr_data, 16'hBEEF);
    stat_is("R2 busy status", 16'h0000);
    done_pulse();
    stat_is("R3 done status", 16'h00C0);

    // R4 sector erase shaping and data masking
    launch_op(16'h3456, 16'hFFFF, 16'h0042);
    chk("R4 sector addr", arr_addr, 16'h3400);
    chk("R4 sector data", arr_data, 16'h0000);
    done_pulse();

    // R4/R11 mass erase in bank 1
    wr(1, 16'd0, 16'h0001);
    launch_op(16'h8ABC, 16'h5555, 16'h0044);
    chk("R4 mass addr", arr_addr, 16'h8ABC);
    chk("R4 mass bank", {15'b0, arr_bank}, 16'h0001);
    done_pulse();
    wr(1, 16'd0, 16'h0000);
    launch_op(16'h0102, 16'h7777, 16'h0006);
    chk("R4 verify data", arr_data, 16'h0000);
    done_pulse();

    // R5 misaligned
    wr(0, 16'h1001, 16'h0000);
    stat_is("R5 misaligned", 16'h00D0);
    wr(1, 16'd1, 16'h0010);
    stat_is("R10 clear ae", 16'h00C0);

    // R6 out of order
    wr(1, 16'd2, 16'h0021);
    stat_is("R6 cmd first", 16'h00D0);
    wr(1, 16'd1, 16'h0010);
    wr(1, 16'd1, 16'h0080);
    stat_is("R6 launch first", 16'h00D0);
    wr(1, 16'd1, 16'h0010);

    // R7 intervening writes
    wr(0, 16'h2000, 16'h1111); wr(0, 16'h2002, 16'h2222);
    stat_is("R7 double array", 16'h00D0);
    wr(1, 16'd1, 16'h0010);
    wr(1, 16'd2, 16'h0021);
    stat_is("R7 discarded", 16'h00D0);
    wr(1, 16'd1, 16'h0010);
    wr(0, 16'h2000, 16'h1111); wr(1, 16'd2, 16'h0021); wr(1, 16'd0, 16'h0001);
    stat_is("R7 cfg mid-seq", 16'h00D0);
    rd(16'd0, v); chk("R7 bank kept", v, 16'h0000);
    wr(1, 16'd1, 16'h0090);
    stat_is("R7 launch after abort", 16'h00D0);
    wr(1, 16'd1, 16'h0010);

    // R8 unknown command
    wr(0, 16'h2000, 16'h1111); wr(1, 16'd2, 16'h0033);
    stat_is("R8 unknown", 16'h00D0);
    wr(1, 16'd1, 16'h0010);

    // R9 protection
    wr(1, 16'd3, 16'h8000);
    wr(0, 16'h9000, 16'h1234);
    stat_is("R9 protected", 16'h00E0);
    wr(1, 16'd1, 16'h0020);
    stat_is("R10 clear pv", 16'h00C0);
    launch_op(16'h7FFE, 16'hA5A5, 16'h0021);
    chk("R9 below limit start", {15'b0, arr_start}, 16'h0001);
    done_pulse();
    wr(1, 16'd3, 16'hFFFF);

    // R10 array write ignored while flag set
    wr(1, 16'd2, 16'h0021);
    wr(0, 16'h0400, 16'h0000);
    wr(1, 16'd1, 16'h0010);
    stat_is("R10 ignored write", 16'h00C0);
    wr(1, 16'd2, 16'h0021);
    stat_is("R10 nothing pending", 16'h00D0);

    // R11 banked flags (bank 0 has ae set)
    wr(1, 16'd0, 16'h0001);
    stat_is("R11 bank1 clean", 16'h00C0);
    wr(1, 16'd0, 16'h0000);
    stat_is("R11 bank0 flagged", 16'h00D0);
    wr(1, 16'd1, 16'h0010);

    // R12 writes while busy
    launch_op(16'h0040, 16'h0F0F, 16'h0021);
    wr(0, 16'h0010, 16'h0000);
    wr(1, 16'd1, 16'h0080);
    stat_is("R12 busy write", 16'h0010);
    chk("R12 no restart", {15'b0, arr_start}, 16'h0000);
    done_pulse();
    stat_is("R12 op completes", 16'h00D0);
    wr(1, 16'd1, 16'h0010);
    stat_is("R10 final clear", 16'h00C0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule